// File: doc/BRIEF.md
# Ripple Adder-Subtractor with Borrow Chain

This block is a combinational N-bit arithmetic unit, 32 bits wide by default. It is built as a linear chain of one-bit cells. A mode input chooses the operation: 0 adds and 1 subtracts.

Subtraction does not invert the second operand and add one. Each cell forms a true difference bit and hands a borrow to the next cell up. Inside each cell, the outgoing link is the carry equation or the borrow equation, picked by the mode. The result bit is the same three-input exclusive-or in both modes.

The external carry/borrow input feeds bit 0. Only the link out of the most significant cell appears on the final carry/borrow output. The outputs follow the inputs with no clock and no storage, so the unit fits inside a larger datapath stage.

Top module: `addsub_ripple`

## Requirements
- R1: With `sub_sel` = 0, `result` equals (`op_a` + `op_b` + `cb_in`) mod 2^WIDTH.
- R2: With `sub_sel` = 0, `cb_out` equals bit WIDTH of the full sum `op_a` + `op_b` + `cb_in`.
- R3: With `sub_sel` = 1, `result` equals (`op_a` - `op_b` - `cb_in`) mod 2^WIDTH.
- R4: With `sub_sel` = 1, `cb_out` is 1 exactly when `op_a` < `op_b` + `cb_in`. With `cb_in` = 0, this means exactly when `op_a` < `op_b`.
- R5: The link into bit 0 reaches the most significant bit:
  - all-ones + 0 with `cb_in` = 1 gives `result` 0 and `cb_out` 1;
  - 0 - 0 with `cb_in` = 1 gives all ones and `cb_out` 1.
- R6: Subtracting equal operands with `cb_in` = 0 gives `result` 0 and `cb_out` 0.
- R7: `result` bit 0 equals `op_a`[0] XOR `op_b`[0] XOR `cb_in` in both modes.
- R8: The unit is combinational. Outputs reflect the present inputs within the same clock period in which the inputs change, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Minuend or first addend |
| op_b | input | WIDTH | Subtrahend or second addend |
| cb_in | input | 1 | Carry-in (add mode) or borrow-in (subtract mode) for bit 0 |
| sub_sel | input | 1 | Operation: 0 adds, 1 subtracts |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| cb_out | output | 1 | Carry or borrow out of the most significant cell |

## Verification
The mode select and the external carry/borrow input act in the same evaluation, and they are combined at every cell of the chain. The worst case is a mode flip while `cb_in` is 1 and the operands make the link ripple through all WIDTH cells. Typical operand pairs are all-ones with zero, and zero with zero.

The bench applies such pairs back to back with the mode toggling between consecutive cycles. This exposes any cell that picks the wrong equation, or that keeps a stale link from the previous mode. Each pair is judged in the same cycle against a reference computed with plain wide addition and subtraction.

// File: rtl/addsub_pkg.sv
`timescale 1ns/1ps
package addsub_pkg;
  // Operation encoding carried on sub_sel
  typedef enum logic {
    MODE_ADD = 1'b0,
    MODE_SUB = 1'b1
  } arith_mode_e;
endpackage

// File: rtl/addsub_cell.sv
`timescale 1ns/1ps
module addsub_cell
  import addsub_pkg::*;
(
  input  logic        a_i,
  input  logic        b_i,
  input  logic        link_i,
  input  arith_mode_e mode_i,
  output logic        r_o,
  output logic        link_o
);
  logic half_x;
  logic carry_nx;
  logic borrow_nx;

  assign half_x = a_i ^ b_i;

  // Sum and difference share the same bit function
  assign r_o = half_x ^ link_i;

  // Carry for addition
  assign carry_nx = (a_i & b_i) | (link_i & half_x);

  // Borrow for subtraction
  assign borrow_nx = (~half_x & link_i) | (~a_i & b_i);

  assign link_o = (mode_i == MODE_SUB) ? borrow_nx : carry_nx;
endmodule

// File: rtl/addsub_chain.sv
`timescale 1ns/1ps
module addsub_chain
  import addsub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             link_i,
  input  arith_mode_e      mode_i,
  output logic [WIDTH-1:0] r_o,
  output logic             link_o
);
  localparam int LINKS = WIDTH + 1;

  logic [LINKS-1:0] link;

  assign link[0] = link_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    addsub_cell u_cell (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .link_i (link[i]),
      .mode_i (mode_i),
      .r_o    (r_o[i]),
      .link_o (link[i+1])
    );
  end

  assign link_o = link[LINKS-1];
endmodule

// File: rtl/addsub_ripple.sv
`timescale 1ns/1ps
module addsub_ripple
  import addsub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             cb_in,
  input  logic             sub_sel,
  output logic [WIDTH-1:0] result,
  output logic             cb_out
);
  arith_mode_e mode;

  assign mode = arith_mode_e'(sub_sel);

  addsub_chain #(.WIDTH(WIDTH)) u_chain (
    .a_i    (op_a),
    .b_i    (op_b),
    .link_i (cb_in),
    .mode_i (mode),
    .r_o    (result),
    .link_o (cb_out)
  );
endmodule

// File: rtl/addsub_ripple_chk.sv
`timescale 1ns/1ps
module addsub_ripple_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             cb_in,
  input logic             sub_sel,
  input logic [WIDTH-1:0] result,
  input logic             cb_out
);
  logic [WIDTH:0] wide_a;
  logic [WIDTH:0] wide_b;
  logic [WIDTH:0] wide_c;
  logic [WIDTH:0] ref_sum;
  logic [WIDTH:0] ref_dif;
  logic           known;

  assign wide_a  = {1'b0, op_a};
  assign wide_b  = {1'b0, op_b};
  assign wide_c  = {{WIDTH{1'b0}}, cb_in};
  assign ref_sum = wide_a + wide_b + wide_c;
  assign ref_dif = wide_a - wide_b - wide_c;
  assign known   = !$isunknown({op_a, op_b, cb_in, sub_sel, result, cb_out});

  always_comb begin
    if (known) begin
      if (!sub_sel) begin
        p_add_sum_r1: assert (result == ref_sum[WIDTH-1:0])
          else $error("add result mismatch");
        p_add_carry_r2: assert (cb_out == ref_sum[WIDTH])
          else $error("add carry mismatch");
      end else begin
        p_sub_dif_r3: assert (result == ref_dif[WIDTH-1:0])
          else $error("sub result mismatch");
        p_sub_borrow_r4: assert (cb_out == (wide_a < (wide_b + wide_c)))
          else $error("sub borrow mismatch");
      end
      p_lsb_xor_r7: assert (result[0] == (op_a[0] ^ op_b[0] ^ cb_in))
        else $error("lsb mismatch");
    end
  end
endmodule

bind addsub_ripple addsub_ripple_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a    (op_a),
  .op_b    (op_b),
  .cb_in   (cb_in),
  .sub_sel (sub_sel),
  .result  (result),
  .cb_out  (cb_out)
);

// File: tb/sim_addsub_ripple.sv
`timescale 1ns/1ps
module sim_addsub_ripple;
  localparam int W = 32;
  localparam int MAX_CYCLES = 200000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         cb_in = 1'b0;
  logic         sub_sel = 1'b0;
  logic [W-1:0] result;
  logic         cb_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         c;
    logic [W-1:0] exp_r;
    logic         exp_cb;
    string        tag_r;
    string        tag_cb;
  } item_t;

  item_t sb[$];

  always #10 clk = ~clk;  // 50 MHz

  addsub_ripple #(.WIDTH(W)) u0 (
    .op_a    (op_a),
    .op_b    (op_b),
    .cb_in   (cb_in),
    .sub_sel (sub_sel),
    .result  (result),
    .cb_out  (cb_out)
  );

  // Driver: applies one operation per cycle and records its expected outcome
  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic c, input logic s,
                       input string tr, input string tc);
    item_t it;
    logic [W:0] wide;
    @(posedge clk);
    #1;
    op_a = a; op_b = b; cb_in = c; sub_sel = s;
    if (s) wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, c};
    else   wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    it.a = a; it.b = b; it.c = c;
    it.exp_r = wide[W-1:0];
    it.exp_cb = wide[W];
    it.tag_r = tr; it.tag_cb = tc;
    sb.push_back(it);
  endtask

  // Monitor: pops at the falling edge of the same cycle, with no clock edge
  // between driving and sampling (R8)
  always @(negedge clk) begin
    if (!rst && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (result !== it.exp_r) begin
        failures++;
        $display("FAIL %s R8 result a=%h b=%h c=%b actual=%h expected=%h",
                 it.tag_r, it.a, it.b, it.c, result, it.exp_r);
      end
      checks++;
      if (cb_out !== it.exp_cb) begin
        failures++;
        $display("FAIL %s carry/borrow a=%h b=%h c=%b actual=%b expected=%b",
                 it.tag_cb, it.a, it.b, it.c, cb_out, it.exp_cb);
      end
      checks++;
      if (result[0] !== (it.a[0] ^ it.b[0] ^ it.c)) begin
        failures++;
        $display("FAIL R7 lsb actual=%b expected=%b",
                 result[0], it.a[0] ^ it.b[0] ^ it.c);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // Idle inputs after reset give zero outputs
    drive('0, '0, 1'b0, 1'b0, "R1", "R2");

    // Full-length carry and borrow ripple
    drive('1, '0, 1'b1, 1'b0, "R5", "R5");
    drive('0, '0, 1'b1, 1'b1, "R5", "R5");
    drive('1, '0, 1'b1, 1'b0, "R5", "R5");
    drive('0, 32'h1, 1'b0, 1'b1, "R3", "R4");
    drive('1, '1, 1'b1, 1'b0, "R1", "R2");
    drive('1, '1, 1'b1, 1'b1, "R3", "R4");

    // Equal operands subtract to zero
    drive(32'h1234_5678, 32'h1234_5678, 1'b0, 1'b1, "R6", "R6");
    drive('1, '1, 1'b0, 1'b1, "R6", "R6");
    drive('0, '0, 1'b0, 1'b1, "R6", "R6");

    // Borrow boundary around a < b
    drive(32'h8000_0000, 32'h8000_0001, 1'b0, 1'b1, "R3", "R4");
    drive(32'h8000_0001, 32'h8000_0000, 1'b0, 1'b1, "R3", "R4");
    drive(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1, "R3", "R4");
    drive(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, "R1", "R2");

    // Single lsb cases in both modes
    drive(32'h1, 32'h0, 1'b1, 1'b0, "R7", "R2");
    drive(32'h1, 32'h0, 1'b1, 1'b1, "R7", "R4");

    // Random operands, both modes, mode flipping every cycle
    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (k % 5 == 0) rb = ra;
      drive(ra, rb, 1'(k % 3 == 0), 1'(k % 2),
            (k % 2) ? "R3" : "R1", (k % 2) ? "R4" : "R2");
    end

    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog R8 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule